// File: doc/BRIEF.md
# Ring Frame Slot Node

This block is one station on a circular serial chain. A single master launches a frame that visits every station in turn and then returns to the master. The frame is a run of equal-sized slots, each holding one packet. The frame arrives one bit per clock with a strobe on its first bit. The node passes the frame on with the same timing. Each node owns exactly one slot. In that slot it takes what the master put there and delivers it as a parallel word. It then replaces the slot's contents with its own packet before the frame moves on. Every other slot leaves unchanged.

A node starts without a slot. While it is unassigned, it examines each slot of each passing frame and takes the first slot in which every bit is zero. It writes its packet, headed by its own nonzero address, into that slot. Downstream nodes therefore see the slot as taken and move on to a later one. When a frame holds no free slot, the node stays unassigned, raises a flag and tries again on the next frame. The slot index it claims is kept until reset.

The frames run at the pace of the fastest station. A node with no new sample still fills its slot on every frame, using an empty packet. The forwarding delay is exactly one slot length. This lets the node see a whole slot before it decides to take it.

Top module: `ring_slot_node`

## Requirements
- R1: While reset is held and directly after it, out_bit, out_sof, rx_valid, assigned and no_slot are all 0.
- R2: out_sof repeats in_sof exactly SLOT_W (112) cycles later. Every bit outside the node's own slot appears on out_bit unchanged, with the same 112-cycle delay.
- R3: An unassigned node claims the first slot, counting from slot 0 at the frame strobe, whose 112 bits are all zero. It sets assigned, reports that position on slot_idx, and overwrites that same slot in the outgoing frame. This includes the last slot of a frame.
- R4: A slot with any single bit set is not free, even when that bit lies outside the address field (for example, only the lowest CRC or data bit). Such a slot is skipped.
- R5: On every frame after the claim, the owned slot leaves as the node's packet, most significant bit first. The packet layout is: address in bits 111..100 (node_addr), timestamp in bits 99..88, command in bits 87..80, data in bits 79..16, and CRC in bits 15..0.
- R6: A sample written with tx_load is sent in the next owned slot only. Once it has been sent, and whenever no sample is pending, the slot carries an empty packet. An empty packet has the own address, and all other fields are zero.
- R7: When an assigned node has received its own slot, rx_pkt holds the 112 received bits (the first bit on the line in bit 111). rx_valid is high for exactly one cycle, in the cycle after the slot's last bit. The frame in which the slot is claimed produces no rx_valid.
- R8: If a frame ends without a free slot, the node stays unassigned and no_slot is 1 from the cycle after the frame's last bit. The node claims on a later frame, and no_slot returns to 0 on the claim.
- R9: Once claimed, slot_idx and assigned hold until reset. No other free slot is claimed, and free slots after the claim are forwarded still zero.
- R10: An unassigned node without a free slot forwards the whole frame bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | 12 | Own nonzero address, held stable |
| in_bit | input | 1 | Serial frame input |
| in_sof | input | 1 | High on the first bit of an incoming frame |
| out_bit | output | 1 | Serial frame output |
| out_sof | output | 1 | High on the first bit of the outgoing frame |
| tx_load | input | 1 | Writes a new sample for the next owned slot |
| tx_ts | input | 12 | Sample timestamp |
| tx_cmd | input | 8 | Sample command |
| tx_data | input | 64 | Sample data |
| tx_crc | input | 16 | Sample CRC |
| rx_valid | output | 1 | One-cycle pulse: rx_pkt has new contents |
| rx_pkt | output | 112 | Contents received in the owned slot |
| assigned | output | 1 | A slot has been claimed |
| slot_idx | output | 2 | Index of the claimed slot |
| no_slot | output | 1 | The last frame ended with no free slot found |

## Verification
The directed tests target the following cases, and show what a faulty node would do in each:

- **Slot with only a low bit set.** A slot whose only set bit is deep in the data or CRC field must be skipped. A node that checks only the address field would write over another station's packet there.
- **Claim in the last slot after a failed frame.** A node that misses this case never leaves the unassigned state, or leaves no_slot stuck high.
- **Second free slot after the claim.** This slot must stay zero. A node that keeps claiming would take slots meant for nodes further down the chain.
- **Timing and reuse.** A sample must be sent exactly once, and rx_valid must appear in exactly the right cycle. A stale sample repeated across frames, or a pulse off by one slot, shows up in the bit-by-bit comparison of the outgoing frame.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  localparam int ADDR_W = 12;
  localparam int TS_W   = 12;
  localparam int CMD_W  = 8;
  localparam int DATA_W = 64;
  localparam int CRC_W  = 16;
  localparam int SLOT_W = ADDR_W + TS_W + CMD_W + DATA_W + CRC_W;

  typedef logic [SLOT_W-1:0] slot_word_t;

  // Packet layout, most significant field first on the line.
  function automatic slot_word_t build_packet(
    input logic [ADDR_W-1:0] addr,
    input logic [TS_W-1:0]   ts,
    input logic [CMD_W-1:0]  cmd,
    input logic [DATA_W-1:0] data,
    input logic [CRC_W-1:0]  crc);
    return {addr, ts, cmd, data, crc};
  endfunction

  // Empty packet: own address keeps the slot marked as occupied.
  function automatic slot_word_t empty_packet(input logic [ADDR_W-1:0] addr);
    return build_packet(addr, '0, '0, '0, '0);
  endfunction
endpackage

// File: rtl/ring_slot_tracker.sv
module ring_slot_tracker #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 112,
  localparam int BIT_W    = $clog2(SLOT_W),
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  output logic             active,
  output logic [BIT_W-1:0] bit_pos,
  output logic [IDX_W-1:0] slot_pos,
  output logic             slot_last,
  output logic             frame_last
);
  logic             run_q;
  logic [BIT_W-1:0] bit_q;
  logic [IDX_W-1:0] slot_q;

  always_comb begin
    active     = sof | run_q;
    bit_pos    = sof ? '0 : bit_q;
    slot_pos   = sof ? '0 : slot_q;
    slot_last  = active && (bit_pos == BIT_W'(SLOT_W - 1));
    frame_last = slot_last && (slot_pos == IDX_W'(NUM_SLOTS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bit_q  <= '0;
      slot_q <= '0;
    end else if (active) begin
      if (slot_last) begin
        bit_q <= '0;
        if (frame_last) begin
          run_q  <= 1'b0;
          slot_q <= '0;
        end else begin
          run_q  <= 1'b1;
          slot_q <= slot_pos + IDX_W'(1);
        end
      end else begin
        run_q  <= 1'b1;
        bit_q  <= bit_pos + BIT_W'(1);
        slot_q <= slot_pos;
      end
    end
  end
endmodule

// File: rtl/ring_delay_line.sv
module ring_delay_line #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 112
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [DEPTH-1:0][WIDTH-1:0] pipe;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[DEPTH-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/ring_slot_node.sv
module ring_slot_node
  import ring_node_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int BIT_W    = $clog2(SLOT_W),
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic              in_bit,
  input  logic              in_sof,
  output logic              out_bit,
  output logic              out_sof,
  input  logic              tx_load,
  input  logic [TS_W-1:0]   tx_ts,
  input  logic [CMD_W-1:0]  tx_cmd,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [CRC_W-1:0]  tx_crc,
  output logic              rx_valid,
  output logic [SLOT_W-1:0] rx_pkt,
  output logic              assigned,
  output logic [IDX_W-1:0]  slot_idx,
  output logic              no_slot
);
  // Input side position
  logic             i_act, i_slast, i_flast;
  logic [BIT_W-1:0] i_bit;
  logic [IDX_W-1:0] i_slot;

  ring_slot_tracker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) in_trk_i (
    .clk(clk), .rst_n(rst_n), .sof(in_sof),
    .active(i_act), .bit_pos(i_bit), .slot_pos(i_slot),
    .slot_last(i_slast), .frame_last(i_flast));

  // Zero scan and deserializer for the slot being received
  logic       zero_acc;
  logic       seg_zero_now;
  slot_word_t cap_q;
  slot_word_t slot_word;
  logic       claim_now;
  logic       own_rx_done;

  always_comb begin
    seg_zero_now = ((i_bit == '0) ? 1'b1 : zero_acc) & ~in_bit;
    slot_word    = {cap_q[SLOT_W-2:0], in_bit};
    claim_now    = i_slast & ~assigned & seg_zero_now;
    own_rx_done  = i_slast & assigned & (i_slot == slot_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_acc <= 1'b1;
      cap_q    <= '0;
    end else if (i_act) begin
      zero_acc <= seg_zero_now;
      cap_q    <= slot_word;
    end
  end

  // Ownership, discovery status and receive path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assigned <= 1'b0;
      slot_idx <= '0;
      no_slot  <= 1'b0;
      rx_valid <= 1'b0;
      rx_pkt   <= '0;
    end else begin
      rx_valid <= own_rx_done;
      if (own_rx_done) rx_pkt <= slot_word;
      if (claim_now) begin
        assigned <= 1'b1;
        slot_idx <= i_slot;
        no_slot  <= 1'b0;
      end else if (i_flast && !assigned) begin
        no_slot <= 1'b1;
      end
    end
  end

  // Fixed forwarding delay of one slot length
  logic [1:0] dl_q;
  ring_delay_line #(.WIDTH(2), .DEPTH(SLOT_W)) dly_i (
    .clk(clk), .rst_n(rst_n), .d({in_sof, in_bit}), .q(dl_q));

  logic d_sof, d_bit;
  assign d_sof = dl_q[1];
  assign d_bit = dl_q[0];

  // Output side position
  logic             o_act, o_slast, o_flast;
  logic [BIT_W-1:0] o_bit;
  logic [IDX_W-1:0] o_slot;

  ring_slot_tracker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) out_trk_i (
    .clk(clk), .rst_n(rst_n), .sof(d_sof),
    .active(o_act), .bit_pos(o_bit), .slot_pos(o_slot),
    .slot_last(o_slast), .frame_last(o_flast));

  // Pending sample and outgoing packet
  logic              pend_valid;
  logic [TS_W-1:0]   pend_ts;
  logic [CMD_W-1:0]  pend_cmd;
  logic [DATA_W-1:0] pend_data;
  logic [CRC_W-1:0]  pend_crc;
  slot_word_t        word_now;
  slot_word_t        snap_q;
  logic              own_out;
  logic              own_first;

  always_comb begin
    word_now  = pend_valid ? build_packet(node_addr, pend_ts, pend_cmd, pend_data, pend_crc)
                           : empty_packet(node_addr);
    own_out   = o_act & assigned & (o_slot == slot_idx);
    own_first = own_out & (o_bit == '0);
    if (!own_out)      out_bit = d_bit;
    else if (own_first) out_bit = word_now[SLOT_W-1];
    else               out_bit = snap_q[BIT_W'(SLOT_W-1) - o_bit];
    out_sof = d_sof;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_ts    <= '0;
      pend_cmd   <= '0;
      pend_data  <= '0;
      pend_crc   <= '0;
      snap_q     <= '0;
    end else begin
      if (own_first) snap_q <= word_now;
      if (tx_load) begin
        pend_valid <= 1'b1;
        pend_ts    <= tx_ts;
        pend_cmd   <= tx_cmd;
        pend_data  <= tx_data;
        pend_crc   <= tx_crc;
      end else if (own_first) begin
        pend_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ring_slot_node_chk.sv
module ring_slot_node_chk #(
  parameter int SLOT_W = 112,
  parameter int IDX_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_sof,
  input logic             out_sof,
  input logic             rx_valid,
  input logic             assigned,
  input logic [IDX_W-1:0] slot_idx,
  input logic             no_slot
);
  localparam int CNT_W = $clog2(SLOT_W + 2);
  logic [CNT_W-1:0] since_sof;
  logic             seen_sof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_sof <= '0;
      seen_sof  <= 1'b0;
    end else if (in_sof) begin
      since_sof <= CNT_W'(1);
      seen_sof  <= 1'b1;
    end else if (since_sof <= CNT_W'(SLOT_W)) begin
      since_sof <= since_sof + CNT_W'(1);
    end
  end

  // R2
  sof_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof && !in_sof) |-> (seen_sof && since_sof == CNT_W'(SLOT_W)));

  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  rx_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> assigned);

  // R9
  assigned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    assigned |=> assigned);

  // R9
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    assigned |=> $stable(slot_idx));

  // R8
  noslot_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(no_slot && assigned));
endmodule

bind ring_slot_node ring_slot_node_chk #(.SLOT_W(ring_node_pkg::SLOT_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .out_sof(out_sof),
  .rx_valid(rx_valid), .assigned(assigned), .slot_idx(slot_idx), .no_slot(no_slot));

// File: tb/ring_slot_node_tb_top.sv
module ring_slot_node_tb_top;
  localparam int NS  = 4;
  localparam int SW  = 112;
  localparam int FW  = NS * SW;
  localparam logic [11:0] ADDR = 12'h5A3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, in_bit, in_sof, out_bit, out_sof;
  logic          tx_load, rx_valid, assigned, no_slot;
  logic [11:0]   node_addr, tx_ts;
  logic [7:0]    tx_cmd;
  logic [63:0]   tx_data;
  logic [15:0]   tx_crc;
  logic [SW-1:0] rx_pkt;
  logic [1:0]    slot_idx;

  ring_slot_node #(.NUM_SLOTS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .node_addr(node_addr), .in_bit(in_bit), .in_sof(in_sof),
    .out_bit(out_bit), .out_sof(out_sof), .tx_load(tx_load), .tx_ts(tx_ts),
    .tx_cmd(tx_cmd), .tx_data(tx_data), .tx_crc(tx_crc), .rx_valid(rx_valid),
    .rx_pkt(rx_pkt), .assigned(assigned), .slot_idx(slot_idx), .no_slot(no_slot));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [SW-1:0] fin  [NS];
  logic [SW-1:0] fout [NS];
  int            sof_at, rx_cnt, rx_at;
  logic [SW-1:0] rx_word;

  function automatic logic [SW-1:0] pkt(input logic [11:0] a, input logic [11:0] t,
                                        input logic [7:0] c, input logic [63:0] d,
                                        input logic [15:0] r);
    logic [SW-1:0] w;
    w = '0;
    w[111:100] = a; w[99:88] = t; w[87:80] = c; w[79:16] = d; w[15:0] = r;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_bit = 0; in_sof = 0; tx_load = 0;
    tx_ts = '0; tx_cmd = '0; tx_data = '0; tx_crc = '0; node_addr = ADDR;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_tx(input logic [11:0] t, input logic [7:0] c,
                         input logic [63:0] d, input logic [15:0] r);
    @(negedge clk);
    tx_load = 1; tx_ts = t; tx_cmd = c; tx_data = d; tx_crc = r;
    @(negedge clk);
    tx_load = 0;
  endtask

  // Drive fin[] as one frame and capture the outgoing frame and rx events.
  task automatic run_frame();
    sof_at = -1; rx_cnt = 0; rx_at = -1; rx_word = '0;
    for (int s = 0; s < NS; s++) fout[s] = '0;
    for (int c = 0; c < FW + SW + 4; c++) begin
      @(negedge clk);
      if (out_sof && sof_at < 0) sof_at = c;
      if (rx_valid) begin rx_cnt++; rx_at = c; rx_word = rx_pkt; end
      if (c >= SW && c < SW + FW) fout[(c - SW) / SW][SW - 1 - ((c - SW) % SW)] = out_bit;
      in_sof = (c == 0);
      in_bit = (c < FW) ? fin[c / SW][SW - 1 - (c % SW)] : 1'b0;
    end
    in_sof = 0; in_bit = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_bit = 0; in_sof = 0; tx_load = 0; node_addr = ADDR;
    repeat (3) @(negedge clk);
    check(out_bit == 0 && out_sof == 0 && rx_valid == 0 && assigned == 0 && no_slot == 0,
          "R1 outputs in reset", {out_bit, out_sof, rx_valid, assigned, no_slot}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(assigned == 0 && no_slot == 0 && out_bit == 0, "R1 after reset",
          {assigned, no_slot, out_bit}, '0);
  endtask

  task automatic t_full_then_last();
    do_reset();
    fin[0] = pkt(12'h111, 12'h0AB, 8'h3C, 64'hDEAD_BEEF_0000_1234, 16'h9999);
    fin[1] = 112'd1;               // only lowest CRC bit set
    fin[2] = 112'd1 << 16;         // only lowest data bit set
    fin[3] = pkt(12'h7FF, 12'h0, 8'h0, 64'h0, 16'h0);
    run_frame();
    check(sof_at == SW, "R2 sof latency", sof_at, SW);
    for (int s = 0; s < NS; s++)
      check(fout[s] == fin[s], "R10 R4 forwarded unchanged", fout[s], fin[s]);
    check(assigned == 0, "R4 skips slot with low bit set", assigned, 0);
    check(no_slot == 1, "R8 no_slot after full frame", no_slot, 1);
    check(rx_cnt == 0, "R7 no rx while unassigned", rx_cnt, 0);
    fin[3] = '0;
    run_frame();
    check(assigned == 1 && slot_idx == 2'd3, "R8 R3 retry claims last slot", slot_idx, 3);
    check(no_slot == 0, "R8 no_slot cleared on claim", no_slot, 0);
    check(fout[3] == pkt(ADDR, 0, 0, 0, 0), "R3 R6 claimed slot gets empty packet",
          fout[3], pkt(ADDR, 0, 0, 0, 0));
    check(fout[1] == fin[1] && fout[2] == fin[2], "R2 other slots kept", fout[2], fin[2]);
  endtask

  task automatic t_claim_and_run();
    logic [SW-1:0] x, e;
    do_reset();
    fin[0] = pkt(12'h222, 12'h001, 8'h10, 64'h1, 16'h2);
    fin[1] = 112'd1 << 40;
    fin[2] = '0;
    fin[3] = '0;
    run_frame();
    check(assigned == 1 && slot_idx == 2'd2, "R3 first free slot", slot_idx, 2);
    check(fout[2] == pkt(ADDR, 0, 0, 0, 0), "R3 own address written", fout[2],
          pkt(ADDR, 0, 0, 0, 0));
    check(fout[3] == '0, "R9 second free slot stays zero", fout[3], '0);
    check(rx_cnt == 0, "R7 no rx in claim frame", rx_cnt, 0);
    // Next frame: master returns content in slot 2, node has a sample
    x = pkt(12'hABC, 12'h321, 8'h77, 64'h0123_4567_89AB_CDEF, 16'hC0DE);
    fin[2] = x;
    load_tx(12'h456, 8'h5A, 64'hFEDC_BA98_7654_3210, 16'hBEEF);
    run_frame();
    e = pkt(ADDR, 12'h456, 8'h5A, 64'hFEDC_BA98_7654_3210, 16'hBEEF);
    check(fout[2] == e, "R5 R6 sample sent in owned slot", fout[2], e);
    check(rx_cnt == 1, "R7 one rx pulse", rx_cnt, 1);
    check(rx_at == 3 * SW, "R7 rx timing", rx_at, 3 * SW);
    check(rx_word == x, "R7 rx contents", rx_word, x);
    check(fout[0] == fin[0] && fout[1] == fin[1] && fout[3] == '0,
          "R9 R2 others forwarded", fout[3], '0);
    check(slot_idx == 2'd2, "R9 index held", slot_idx, 2);
    // Third frame: no new sample, so an empty packet
    fin[2] = pkt(12'h001, 12'h002, 8'h03, 64'h4, 16'h5);
    run_frame();
    check(fout[2] == pkt(ADDR, 0, 0, 0, 0), "R6 empty packet after sample used", fout[2],
          pkt(ADDR, 0, 0, 0, 0));
    check(rx_word == fin[2], "R7 rx next frame", rx_word, fin[2]);
  endtask

  task automatic t_claim_slot0();
    do_reset();
    for (int s = 0; s < NS; s++) fin[s] = '0;
    run_frame();
    check(assigned == 1 && slot_idx == 2'd0, "R3 claim slot 0", slot_idx, 0);
    check(fout[1] == '0 && fout[2] == '0 && fout[3] == '0, "R9 later free slots zero",
          fout[1], '0);
  endtask

  initial begin
    t_reset();
    t_full_then_last();
    t_claim_and_run();
    t_claim_slot0();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule